// File: doc/BRIEF.md
# Command/Response Buffer Host Register Interface

This block is the memory-mapped front end of a security coprocessor that takes commands through a shared buffer. A host bus master reaches a 4 KiB window through a plain slave port. The port carries an address, read and write strobes, an access size of 1, 2, 4 or 8 bytes, and 64-bit write and read data. The low 128 bytes of the window hold control registers. The rest is the shared command/response buffer. Address bits above the window offset name the locality that a start request comes from.

The host claims the single locality and wakes the device with a ready request. It writes a command into the buffer and rings the start doorbell. The block then gives the backend a one-cycle start pulse, with the command length taken from the command header inside the buffer. The backend answers with a done pulse and an error flag. A cancel doorbell forwards a cancel pulse while a command is running. An idle request zeroes the buffer and shuts off buffer access.

Top module: `crb_host_if`

## Requirements
- R1: After reset these registers read as follows. Locality state (0x00) reads 0x80, with bit 0 taken from the established flag. Status (0x44) reads 0x2, where bit 1 is idle and bit 0 is fatal error. Command size (0x58) and response size (0x64) read 0xF80. Command address low (0x5C) and response address low (0x68) read the window base plus 0x80. Command address high (0x60) and response address high (0x6C) read 0.
- R2: Interface ID low (0x30) reads 0x00025811 and interface ID high (0x34) reads the VENDOR_ID parameter in bits 15:0.
- R3: rdata_o is updated at the clock edge that samples rd_i. Register reads use the address aligned down to 4 bytes. Buffer reads use the exact byte address. size_i selects the number of bytes: 0 for 1, 1 for 2, 2 for 4, 3 for 8. Unused upper bytes read 0. An 8-byte register read returns the next register in bits 63:32.
- R4: Writing 1 to request (0x40) clears idle. Writing 2 sets idle and zeroes the whole buffer. Request writes are ignored while start reads 1.
- R5: Writing 1 to start (0x4C) is accepted only if start is 0, idle is 0, the locality is assigned and address bits 14:12 are 0. When accepted, start reads 1 and start_o is high for exactly one cycle, in the cycle after the write.
- R6: With start_o, cmd_len_o carries the big-endian 32-bit value in buffer bytes 2..5 (byte 2 most significant), clamped to 0xF80.
- R7: A done_i pulse while start is 1 returns start to 0. If done_err_i is also high, status bit 0 is set and stays set. done_i while start is 0 is ignored.
- R8: Writing 1 to cancel (0x48) raises cancel_o for one cycle only while idle is 0 and start is 1. Otherwise the write has no effect.
- R9: Writing 1 to locality control (0x08) sets granted (locality status bit 0), clears seized (bit 1) and sets assigned (locality state bit 1). Writing 2 clears assigned and granted. Any other value has no effect.
- R10: While idle is 1, buffer writes are dropped and buffer reads return 0.
- R11: Bit 0 of locality state reads the inverse of established_i.
- R12: Interrupt enable (0x50) and interrupt status (0x54) hold the 32-bit value last written. Unlisted offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | Bits 11:0 window offset, bits 14:12 locality |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| size_i | input | 2 | Access size code |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, registered |
| established_i | input | 1 | Established flag from the backend |
| start_o | output | 1 | Command start pulse |
| cmd_len_o | output | 32 | Clamped command length |
| done_i | input | 1 | Backend completion pulse |
| done_err_i | input | 1 | Backend error flag, valid with done_i |
| cancel_o | output | 1 | Cancel pulse to the backend |

## Verification
The bench targets the gating of the start doorbell. It tries start with no locality claimed, with a nonzero locality in the address, with a wrong value, and while a command is running. A design that missed any one of these would emit an extra start_o pulse. The bench clamps an oversized header length and uses odd byte lanes in the buffer, so a little-endian length or a missing clamp gives a wrong cmd_len_o. It sends a done pulse while nothing is in flight and issues an idle request while busy, which catches a design that takes a stray fatal error or drops the buffer mid-command. It reads the buffer back after an idle cycle to catch a clear that never happens.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int unsigned OFF_LOC_STATE   = 'h000;
  localparam int unsigned OFF_LOC_CTRL    = 'h008;
  localparam int unsigned OFF_LOC_STS     = 'h00C;
  localparam int unsigned OFF_IFID_LO     = 'h030;
  localparam int unsigned OFF_IFID_HI     = 'h034;
  localparam int unsigned OFF_REQ         = 'h040;
  localparam int unsigned OFF_STS         = 'h044;
  localparam int unsigned OFF_CANCEL      = 'h048;
  localparam int unsigned OFF_START       = 'h04C;
  localparam int unsigned OFF_INT_EN      = 'h050;
  localparam int unsigned OFF_INT_STS     = 'h054;
  localparam int unsigned OFF_CMD_SIZE    = 'h058;
  localparam int unsigned OFF_CMD_ADDR_LO = 'h05C;
  localparam int unsigned OFF_RSP_SIZE    = 'h064;
  localparam int unsigned OFF_RSP_ADDR_LO = 'h068;

  localparam logic [31:0] REQ_READY   = 32'd1;
  localparam logic [31:0] REQ_IDLE    = 32'd2;
  localparam logic [31:0] LOC_CLAIM   = 32'd1;
  localparam logic [31:0] LOC_RELEASE = 32'd2;
  localparam logic [31:0] DOORBELL    = 32'd1;
  localparam logic [2:0]  HOME_LOC    = 3'd0;

  // type 1, version 1, xfer cap 3, buffer-capable, selector 1
  localparam logic [31:0] IFID_LO_VAL = 32'h0002_5811;

  function automatic logic [7:0] size_be(input logic [1:0] s);
    case (s)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [63:0] size_mask(input logic [1:0] s);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{size_be(s)[b]}};
    return m;
  endfunction
endpackage

// File: rtl/crb_locality.sv
module crb_locality (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        assigned_o,
  output logic        granted_o,
  output logic        seized_o
);
  import crb_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      assigned_o <= 1'b0;
      granted_o  <= 1'b0;
      seized_o   <= 1'b0;
    end else if (wr_i) begin
      if (wdata_i == LOC_CLAIM) begin
        assigned_o <= 1'b1;
        granted_o  <= 1'b1;
        seized_o   <= 1'b0;
      end else if (wdata_i == LOC_RELEASE) begin
        assigned_o <= 1'b0;
        granted_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crb_databuf.sv
module crb_databuf #(
  parameter int unsigned BUF_WORDS = 496,
  localparam int unsigned IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [2:0]       lane_i,
  input  logic [1:0]       size_i,
  input  logic [63:0]      wdata_i,
  output logic [63:0]      rdata_o,
  output logic [31:0]      hdr_len_o
);
  import crb_pkg::*;

  logic [63:0]          mem [BUF_WORDS];
  logic [BUF_WORDS-1:0] vld;
  logic                 in_rng;
  logic [63:0]          cur, hdr, merged, wsh;
  logic [7:0]           be;

  assign in_rng = 32'(idx_i) < BUF_WORDS;

  always_comb begin
    cur = (in_rng && vld[idx_i]) ? mem[idx_i] : '0;
    hdr = vld[0] ? mem[0] : '0;
    rdata_o   = (cur >> {lane_i, 3'b000}) & size_mask(size_i);
    hdr_len_o = {hdr[23:16], hdr[31:24], hdr[39:32], hdr[47:40]};
    be  = size_be(size_i) << lane_i;
    wsh = wdata_i << {lane_i, 3'b000};
    for (int b = 0; b < 8; b++)
      merged[b*8 +: 8] = be[b] ? wsh[b*8 +: 8] : cur[b*8 +: 8];
  end

  // valid bits stand in for a full clear: an unwritten word reads as zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 vld <= '0;
    else if (clr_i)              vld <= '0;
    else if (wr_i && in_rng)     vld[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i && in_rng) mem[idx_i] <= merged;
  end
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile #(
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned BUF_BYTES = 3968,
  parameter logic [31:0] BUF_BASE  = 32'hFED4_0080,
  parameter logic [15:0] VENDOR_ID = 16'hCAFE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [2:0]       loc_i,
  input  logic [31:0]      wdata_i,
  input  logic [OFF_W-1:0] rd_off_lo_i,
  input  logic [OFF_W-1:0] rd_off_hi_i,
  input  logic             established_i,
  input  logic             done_i,
  input  logic             done_err_i,
  input  logic [31:0]      hdr_len_i,
  input  logic             loc_assigned_i,
  input  logic             loc_granted_i,
  input  logic             loc_seized_i,
  output logic [31:0]      rd_lo_o,
  output logic [31:0]      rd_hi_o,
  output logic             idle_o,
  output logic             busy_o,
  output logic             clr_buf_o,
  output logic             start_o,
  output logic [31:0]      cmd_len_o,
  output logic             cancel_o
);
  import crb_pkg::*;

  localparam logic [31:0] BUF_SZ = 32'(BUF_BYTES);

  logic        fatal_q;
  logic [31:0] int_en_q, int_sts_q;
  logic        req_wr, start_ok, cancel_ok;
  logic [31:0] len_clamped;

  always_comb begin
    req_wr      = wr_i && off_i == OFF_W'(OFF_REQ) && !busy_o;
    clr_buf_o   = req_wr && wdata_i == REQ_IDLE;
    start_ok    = wr_i && off_i == OFF_W'(OFF_START) && wdata_i == DOORBELL &&
                  !busy_o && !idle_o && loc_assigned_i && loc_i == HOME_LOC;
    cancel_ok   = wr_i && off_i == OFF_W'(OFF_CANCEL) && wdata_i == DOORBELL &&
                  !idle_o && busy_o;
    len_clamped = (hdr_len_i > BUF_SZ) ? BUF_SZ : hdr_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_o    <= 1'b1;
      busy_o    <= 1'b0;
      fatal_q   <= 1'b0;
      start_o   <= 1'b0;
      cancel_o  <= 1'b0;
      cmd_len_o <= '0;
      int_en_q  <= '0;
      int_sts_q <= '0;
    end else begin
      start_o  <= start_ok;
      cancel_o <= cancel_ok;
      if (req_wr && wdata_i == REQ_READY) idle_o <= 1'b0;
      else if (clr_buf_o)                 idle_o <= 1'b1;
      if (start_ok) begin
        busy_o    <= 1'b1;
        cmd_len_o <= len_clamped;
      end else if (busy_o && done_i) begin
        busy_o <= 1'b0;
        if (done_err_i) fatal_q <= 1'b1;
      end
      if (wr_i && off_i == OFF_W'(OFF_INT_EN))  int_en_q  <= wdata_i;
      if (wr_i && off_i == OFF_W'(OFF_INT_STS)) int_sts_q <= wdata_i;
    end
  end

  function automatic logic [31:0] reg_word(input logic [OFF_W-1:0] o);
    case (32'(o))
      OFF_LOC_STATE:   return {24'h0, 1'b1, 2'b00, HOME_LOC, loc_assigned_i, ~established_i};
      OFF_LOC_STS:     return {30'h0, loc_seized_i, loc_granted_i};
      OFF_IFID_LO:     return IFID_LO_VAL;
      OFF_IFID_HI:     return {16'h0, VENDOR_ID};
      OFF_STS:         return {30'h0, idle_o, fatal_q};
      OFF_START:       return {31'h0, busy_o};
      OFF_INT_EN:      return int_en_q;
      OFF_INT_STS:     return int_sts_q;
      OFF_CMD_SIZE:    return BUF_SZ;
      OFF_CMD_ADDR_LO: return BUF_BASE;
      OFF_RSP_SIZE:    return BUF_SZ;
      OFF_RSP_ADDR_LO: return BUF_BASE;
      default:         return 32'h0;
    endcase
  endfunction

  assign rd_lo_o = reg_word(rd_off_lo_i);
  assign rd_hi_o = reg_word(rd_off_hi_i);
endmodule

// File: rtl/crb_host_if.sv
module crb_host_if #(
  parameter int unsigned WIN_BYTES = 4096,
  parameter int unsigned BUF_OFF   = 128,
  parameter logic [31:0] WIN_BASE  = 32'hFED4_0000,
  parameter logic [15:0] VENDOR_ID = 16'hCAFE,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
  localparam int unsigned ADDR_W   = OFF_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  input  logic              established_i,
  output logic              start_o,
  output logic [31:0]       cmd_len_o,
  input  logic              done_i,
  input  logic              done_err_i,
  output logic              cancel_o
);
  import crb_pkg::*;

  localparam int unsigned BUF_BYTES = WIN_BYTES - BUF_OFF;
  localparam int unsigned BUF_WORDS = BUF_BYTES / 8;
  localparam int unsigned IDX_W     = $clog2(BUF_WORDS);

  logic [OFF_W-1:0] off, boff, reg_off, reg_off_hi;
  logic [2:0]       loc;
  logic             is_buf, idle, busy, clr_buf, reg_wr, buf_wr, loc_wr;
  logic             loc_assigned, loc_granted, loc_seized;
  logic [31:0]      rd_lo, rd_hi, hdr_len;
  logic [63:0]      buf_rd, reg_rd;

  assign off        = addr_i[OFF_W-1:0];
  assign loc        = addr_i[ADDR_W-1:OFF_W];
  assign is_buf     = 32'(off) >= BUF_OFF;
  assign boff       = off - OFF_W'(BUF_OFF);
  assign reg_off    = {off[OFF_W-1:2], 2'b00};
  assign reg_off_hi = reg_off + OFF_W'(4);
  assign reg_wr     = wr_i && !is_buf;
  assign buf_wr     = wr_i && is_buf && !idle;
  assign loc_wr     = reg_wr && reg_off == OFF_W'(OFF_LOC_CTRL);
  assign reg_rd     = {rd_hi, rd_lo} & size_mask(size_i);

  crb_locality i_loc (
    .clk_i, .rst_ni,
    .wr_i       (loc_wr),
    .wdata_i    (wdata_i[31:0]),
    .assigned_o (loc_assigned),
    .granted_o  (loc_granted),
    .seized_o   (loc_seized)
  );

  crb_databuf #(.BUF_WORDS(BUF_WORDS)) i_buf (
    .clk_i, .rst_ni,
    .wr_i      (buf_wr),
    .clr_i     (clr_buf),
    .idx_i     (boff[IDX_W+2:3]),
    .lane_i    (boff[2:0]),
    .size_i,
    .wdata_i,
    .rdata_o   (buf_rd),
    .hdr_len_o (hdr_len)
  );

  crb_regfile #(
    .OFF_W(OFF_W), .BUF_BYTES(BUF_BYTES),
    .BUF_BASE(WIN_BASE + 32'(BUF_OFF)), .VENDOR_ID(VENDOR_ID)
  ) i_regs (
    .clk_i, .rst_ni,
    .wr_i           (reg_wr),
    .off_i          (reg_off),
    .loc_i          (loc),
    .wdata_i        (wdata_i[31:0]),
    .rd_off_lo_i    (reg_off),
    .rd_off_hi_i    (reg_off_hi),
    .established_i,
    .done_i,
    .done_err_i,
    .hdr_len_i      (hdr_len),
    .loc_assigned_i (loc_assigned),
    .loc_granted_i  (loc_granted),
    .loc_seized_i   (loc_seized),
    .rd_lo_o        (rd_lo),
    .rd_hi_o        (rd_hi),
    .idle_o         (idle),
    .busy_o         (busy),
    .clr_buf_o      (clr_buf),
    .start_o,
    .cmd_len_o,
    .cancel_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= is_buf ? (idle ? '0 : buf_rd) : reg_rd;
  end
endmodule

// File: rtl/crb_host_if_chk.sv
module crb_host_if_chk #(
  parameter int unsigned BUF_BYTES = 3968
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_i,
  input logic [63:0] rdata_o,
  input logic        is_buf,
  input logic        idle,
  input logic        busy,
  input logic        start_o,
  input logic [31:0] cmd_len_o,
  input logic        done_i,
  input logic        cancel_o
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R5
  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy && !idle); // R5
  AST_LEN_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> cmd_len_o <= 32'(BUF_BYTES)); // R6
  AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && done_i) |=> !busy); // R7
  AST_CANCEL_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |-> $past(busy && !idle)); // R8
  AST_IDLE_BUF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_buf && idle) |=> rdata_o == 64'h0); // R10
endmodule

bind crb_host_if crb_host_if_chk #(.BUF_BYTES(BUF_BYTES)) i_chk (
  .clk_i, .rst_ni, .rd_i, .rdata_o,
  .is_buf(is_buf), .idle(idle), .busy(busy),
  .start_o, .cmd_len_o, .done_i, .cancel_o
);

// File: tb/test_crb_host_if.sv
module test_crb_host_if;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [14:0] addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  size_i = 2'd2;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        established_i = 1'b0;
  logic        start_o;
  logic [31:0] cmd_len_o;
  logic        done_i = 1'b0, done_err_i = 1'b0;
  logic        cancel_o;

  int checks = 0, errors = 0;
  logic [63:0] rd_val;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crb_host_if i_crb_host_if (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [1:0] s, input logic [63:0] d);
    @(negedge clk_i);
    addr_i = a; size_i = s; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [1:0] s);
    @(negedge clk_i);
    addr_i = a; size_i = s; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    rd_val = rdata_o;
  endtask

  task automatic done_pulse(input logic err);
    @(negedge clk_i);
    done_i = 1'b1; done_err_i = err;
    @(negedge clk_i);
    done_i = 1'b0; done_err_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R5 start_o after reset", 64'(start_o), 64'h0);
    rd(15'h000, 2'd2); chk("R1 loc state", rd_val, 64'h81);
    rd(15'h044, 2'd2); chk("R1 status", rd_val, 64'h2);
    rd(15'h058, 2'd2); chk("R1 cmd size", rd_val, 64'hF80);
    rd(15'h064, 2'd2); chk("R1 rsp size", rd_val, 64'hF80);
    rd(15'h05C, 2'd3); chk("R1 cmd addr lo/hi", rd_val, 64'h0000_0000_FED4_0080);
    rd(15'h068, 2'd3); chk("R1 rsp addr", rd_val, 64'h0000_0000_FED4_0080);
    rd(15'h030, 2'd2); chk("R2 ifid lo", rd_val, 64'h0002_5811);
    rd(15'h034, 2'd2); chk("R2 ifid hi", rd_val, 64'hCAFE);
  endtask

  task automatic t_lanes;
    rd(15'h031, 2'd0); chk("R3 byte read aligned down", rd_val, 64'h11);
    rd(15'h030, 2'd1); chk("R3 half read", rd_val, 64'h5811);
    rd(15'h030, 2'd3); chk("R3 eight-byte reg read", rd_val, 64'h0000_CAFE_0002_5811);
  endtask

  task automatic t_idle_buf;
    wr(15'h080, 2'd3, 64'hDEAD_BEEF_0BAD_F00D);
    rd(15'h080, 2'd3); chk("R10 idle read zero", rd_val, 64'h0);
    wr(15'h040, 2'd2, 64'd1);
    rd(15'h044, 2'd2); chk("R4 ready clears idle", rd_val, 64'h0);
    rd(15'h080, 2'd3); chk("R10 idle write dropped", rd_val, 64'h0);
  endtask

  task automatic t_buf_lanes;
    wr(15'h080, 2'd3, 64'h1122_3344_5566_7788);
    wr(15'h083, 2'd0, 64'hAA);
    rd(15'h080, 2'd3); chk("R3 buffer byte write merge", rd_val, 64'h1122_3344_AA66_7788);
    rd(15'h083, 2'd0); chk("R3 buffer byte read", rd_val, 64'hAA);
    rd(15'h086, 2'd1); chk("R3 buffer half read", rd_val, 64'h1122);
  endtask

  task automatic t_start_reject;
    wr(15'h04C, 2'd2, 64'd1);
    chk("R5 start without locality", 64'(start_o), 64'h0);
    wr(15'h008, 2'd2, 64'd1);
    rd(15'h000, 2'd2); chk("R9 claim sets assigned", rd_val, 64'h83);
    rd(15'h00C, 2'd2); chk("R9 claim sets granted", rd_val, 64'h1);
    wr(15'h104C, 2'd2, 64'd1);
    chk("R5 start from locality 1", 64'(start_o), 64'h0);
    wr(15'h04C, 2'd2, 64'd2);
    chk("R5 start wrong value", 64'(start_o), 64'h0);
    rd(15'h04C, 2'd2); chk("R5 start still clear", rd_val, 64'h0);
    wr(15'h048, 2'd2, 64'd1);
    chk("R8 cancel while not busy", 64'(cancel_o), 64'h0);
  endtask

  task automatic t_start_run;
    // header bytes 80 01 00 00 00 0A: length 10
    wr(15'h080, 2'd3, 64'h0000_0A00_0000_0180);
    wr(15'h04C, 2'd2, 64'd1);
    chk("R5 start pulse", 64'(start_o), 64'h1);
    chk("R6 command length", 64'(cmd_len_o), 64'd10);
    @(negedge clk_i);
    chk("R5 start pulse one cycle", 64'(start_o), 64'h0);
    rd(15'h04C, 2'd2); chk("R5 start reads 1", rd_val, 64'h1);
    wr(15'h04C, 2'd2, 64'd1);
    chk("R5 start while busy", 64'(start_o), 64'h0);
    wr(15'h040, 2'd2, 64'd2);
    rd(15'h044, 2'd2); chk("R4 idle request ignored while busy", rd_val, 64'h0);
    wr(15'h048, 2'd2, 64'd1);
    chk("R8 cancel while busy", 64'(cancel_o), 64'h1);
    @(negedge clk_i);
    chk("R8 cancel one cycle", 64'(cancel_o), 64'h0);
    done_pulse(1'b0);
    rd(15'h04C, 2'd2); chk("R7 done clears start", rd_val, 64'h0);
    rd(15'h044, 2'd2); chk("R7 clean done no fatal", rd_val, 64'h0);
    done_pulse(1'b1);
    rd(15'h044, 2'd2); chk("R7 done while not busy ignored", rd_val, 64'h0);
  endtask

  task automatic t_clamp_err;
    // length 0x00010000 via byte 3
    wr(15'h080, 2'd3, 64'h0000_0000_0100_0180);
    wr(15'h04C, 2'd2, 64'd1);
    chk("R6 length clamped", 64'(cmd_len_o), 64'hF80);
    done_pulse(1'b1);
    rd(15'h044, 2'd2); chk("R7 error sets fatal", rd_val, 64'h1);
  endtask

  task automatic t_go_idle;
    wr(15'h040, 2'd2, 64'd2);
    rd(15'h044, 2'd2); chk("R4 idle request sets idle", rd_val, 64'h3);
    wr(15'h040, 2'd2, 64'd1);
    rd(15'h080, 2'd3); chk("R4 buffer zeroed", rd_val, 64'h0);
  endtask

  task automatic t_locality_misc;
    wr(15'h008, 2'd2, 64'd8);
    rd(15'h000, 2'd2); chk("R9 other value no effect", rd_val, 64'h83);
    wr(15'h008, 2'd2, 64'd2);
    rd(15'h000, 2'd2); chk("R9 release clears assigned", rd_val, 64'h81);
    rd(15'h00C, 2'd2); chk("R9 release clears granted", rd_val, 64'h0);
    wr(15'h04C, 2'd2, 64'd1);
    chk("R5 start after release", 64'(start_o), 64'h0);
    @(negedge clk_i) established_i = 1'b1;
    rd(15'h000, 2'd2); chk("R11 established inverted", rd_val, 64'h80);
    established_i = 1'b0;
    wr(15'h050, 2'd2, 64'h8000_0005);
    rd(15'h050, 2'd2); chk("R12 int enable holds", rd_val, 64'h8000_0005);
    wr(15'h054, 2'd2, 64'h0000_000A);
    rd(15'h054, 2'd2); chk("R12 int status holds", rd_val, 64'hA);
    wr(15'h020, 2'd2, 64'h1234_5678);
    rd(15'h020, 2'd2); chk("R12 unlisted offset reads zero", rd_val, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_lanes;
    t_idle_buf;
    t_buf_lanes;
    t_start_reject;
    t_start_run;
    t_clamp_err;
    t_go_idle;
    t_locality_misc;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule